// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block holds the software-visible registers of one descriptor-driven DMA channel. The bus is 32 bits wide and accepts only full-word accesses. Software never writes the channel status word directly. It writes a control word whose upper half selects which status bits change and whose lower half supplies their new values. The block then applies the side effects of the run, pause and wake bits: it derives the active and dead flags, and it turns the flush request into a single-cycle pulse toward the attached device.

After every control write that leaves the channel active, the block sends a single-cycle kick to the descriptor sequencer. The sequencer reports a fatal error through a kill input, which marks the channel dead and stops it. The block also holds the descriptor command pointer and three condition-select words (interrupt, branch, wait), and exports them to the sequencer. It does not walk descriptors or evaluate conditions.

Register index is address bits 5:2. Index 0 is control, 1 is status, 4 is the command pointer, and 5, 6 and 7 are the interrupt, branch and wait selects. Status bit positions: run 15, pause 14, flush 13, wake 12, dead 11, active 10, device status 7:0.

Top module: `dmareg_chan`

## Requirements
- R1: After reset every register reads zero, and the kick and flush outputs are low.
- R2: A control write changes a status bit only where its mask bit (data bit 16+n) is 1 and bit n is one of run, pause, flush, wake or device status 7:0. That bit takes data bit n; every other status bit keeps its value.
- R3: Status bits 11:8 are never loaded from control write data, whatever the mask says.
- R4: After a control write, wake=1 forces active=1, and run=1 forces active=1 and dead=0.
- R5: After a control write, pause=1 forces active=0, and this overrides run and wake.
- R6: A control write that changes run from 1 to 0 clears both active and dead.
- R7: A control write that leaves flush at 1 raises dev_flush for exactly one cycle, on the cycle after the write. The stored flush bit always reads 0.
- R8: seq_kick pulses for one cycle, on the cycle after a control write, exactly when that write leaves active set. It stays low otherwise.
- R9: Command pointer writes are ignored while active is 1. An accepted write stores the data with bits 3:0 forced to 0.
- R10: Reads return data one cycle after reg_rd, with reg_rvalid high for that cycle. The control word, index 2, index 3 and indices 8 to 15 read as zero, and writes to them have no effect.
- R11: An access whose byte enables are not all ones changes no register and reads as zero.
- R12: The three select registers store the full written word, read it back, and drive it on their output ports.
- R13: A seq_kill pulse sets dead and clears active. It is applied after any control update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Byte address within the channel window |
| reg_be | input | 4 | Byte enables; only 4'hF is a legal access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| reg_rvalid | output | 1 | Read data valid |
| seq_kill | input | 1 | Sequencer fatal error: mark dead, stop |
| chan_status | output | 16 | Current status word |
| chan_cmdptr | output | 32 | Command pointer |
| intr_sel | output | 32 | Interrupt condition select |
| branch_sel | output | 32 | Branch condition select |
| wait_sel | output | 32 | Wait condition select |
| seq_kick | output | 1 | Start pulse to the sequencer |
| dev_flush | output | 1 | Flush pulse to the device |

## Verification
The hardest state to reach from the ports is dead=1 together with run=1. Control writes alone can never produce it, because run clears dead. The bench therefore first starts the channel and then pulses seq_kill. It can then show both outcomes from that state: a run-clearing write clears dead, and a run-setting write revives the channel. A sweep of all 256 mask/value combinations of the four upper control bits also covers pause, wake and flush in every mixture. Kills are interleaved into that sweep so that dead is set at many points.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
  localparam int ST_W    = 16;
  localparam int IDX_W   = 4;
  localparam int NUM_SEL = 3;

  localparam int B_RUN   = 15;
  localparam int B_PAUSE = 14;
  localparam int B_FLUSH = 13;
  localparam int B_WAKE  = 12;
  localparam int B_DEAD  = 11;
  localparam int B_ACT   = 10;

  // bits software may change through the control word
  localparam logic [ST_W-1:0] CTL_WMASK = 16'hF0FF;

  localparam logic [IDX_W-1:0] IDX_CTL  = 4'd0;
  localparam logic [IDX_W-1:0] IDX_STAT = 4'd1;
  localparam logic [IDX_W-1:0] IDX_PTR  = 4'd4;
  localparam logic [IDX_W-1:0] IDX_SEL0 = 4'd5;
endpackage

// File: rtl/dmareg_stat.sv
module dmareg_stat
  import dmareg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_we,
  input  logic [31:0]     ctl_word,
  input  logic            kill_i,
  output logic [ST_W-1:0] status_o,
  output logic            kick_o,
  output logic            flush_o
);
  logic [ST_W-1:0] status_q, msk, val, mix;
  logic flush_req, kick_req;

  always_comb begin
    msk = ctl_word[31:16] & CTL_WMASK;
    val = ctl_word[15:0]  & CTL_WMASK;
    mix = status_q;
    if (ctl_we) begin
      mix = (val & msk) | (status_q & ~msk);
      if (mix[B_WAKE]) mix[B_ACT] = 1'b1;
      if (mix[B_RUN]) begin
        mix[B_ACT]  = 1'b1;
        mix[B_DEAD] = 1'b0;
      end
      if (mix[B_PAUSE]) mix[B_ACT] = 1'b0;
      if (status_q[B_RUN] && !mix[B_RUN]) begin
        mix[B_ACT]  = 1'b0;
        mix[B_DEAD] = 1'b0;
      end
    end
    flush_req  = ctl_we && mix[B_FLUSH];
    mix[B_FLUSH] = 1'b0;
    if (kill_i) begin
      mix[B_ACT]  = 1'b0;
      mix[B_DEAD] = 1'b1;
    end
    kick_req = ctl_we && mix[B_ACT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      kick_o   <= 1'b0;
      flush_o  <= 1'b0;
    end else begin
      status_q <= mix;
      kick_o   <= kick_req;
      flush_o  <= flush_req;
    end
  end

  assign status_o = status_q;

  // R5
  pause_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && ctl_word[16+B_PAUSE] && ctl_word[B_PAUSE] |=> !status_o[B_ACT]);
  // R6
  run_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && status_o[B_RUN] && ctl_word[16+B_RUN] && !ctl_word[B_RUN] && !kill_i
    |=> !status_o[B_ACT] && !status_o[B_DEAD]);
  // R8
  kick_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_o |-> status_o[B_ACT]);
  // R7
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> $past(ctl_we) && !status_o[B_FLUSH]);
endmodule

// File: rtl/dmareg_ptr.sv
module dmareg_ptr
  import dmareg_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NSEL = NUM_SEL
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic [DW-1:0]             wdata_i,
  input  logic                      lock_i,
  output logic [DW-1:0]             ptr_o,
  output logic [NSEL-1:0][DW-1:0]   sel_o
);
  localparam int ALIGN = 4;
  logic [DW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (wr_i && idx_i == IDX_PTR && !lock_i)
      ptr_q <= {wdata_i[DW-1:ALIGN], {ALIGN{1'b0}}};
  end
  assign ptr_o = ptr_q;

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(int'(IDX_SEL0) + g);
    logic [DW-1:0] sel_q;
    always_ff @(posedge clk) begin
      if (!rst_n) sel_q <= '0;
      else if (wr_i && idx_i == MY_IDX) sel_q <= wdata_i;
    end
    assign sel_o[g] = sel_q;
  end

  // R9
  ptr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr_q) |-> $past(wr_i && !lock_i && idx_i == IDX_PTR));
endmodule

// File: rtl/dmareg_rdmux.sv
module dmareg_rdmux
  import dmareg_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NSEL = NUM_SEL
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_i,
  input  logic                    ok_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [ST_W-1:0]         status_i,
  input  logic [DW-1:0]           ptr_i,
  input  logic [NSEL-1:0][DW-1:0] sel_i,
  output logic [DW-1:0]           rdata_o,
  output logic                    rvalid_o
);
  logic [DW-1:0] mux;

  always_comb begin
    mux = '0;
    if (idx_i == IDX_STAT) mux = DW'(status_i);
    if (idx_i == IDX_PTR)  mux = ptr_i;
    for (int i = 0; i < NSEL; i++)
      if (idx_i == IDX_W'(int'(IDX_SEL0) + i)) mux = sel_i[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rdata_o  <= (rd_i && ok_i) ? mux : '0;
      rvalid_o <= rd_i;
    end
  end

  // R10
  ctl_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_o && $past(idx_i == IDX_CTL) |-> rdata_o == '0);
endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan
  import dmareg_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [3:0]    reg_be,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          reg_rvalid,
  input  logic          seq_kill,
  output logic [15:0]   chan_status,
  output logic [DW-1:0] chan_cmdptr,
  output logic [DW-1:0] intr_sel,
  output logic [DW-1:0] branch_sel,
  output logic [DW-1:0] wait_sel,
  output logic          seq_kick,
  output logic          dev_flush
);
  logic [IDX_W-1:0] idx;
  logic             ok, ctl_we, wr_ok;
  logic [NUM_SEL-1:0][DW-1:0] sels;

  assign idx    = reg_addr[IDX_W+1:2];
  assign ok     = (reg_be == 4'hF);
  assign wr_ok  = reg_wr && ok;
  assign ctl_we = wr_ok && idx == IDX_CTL;

  dmareg_stat u_stat (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_word(reg_wdata[31:0]),
    .kill_i(seq_kill), .status_o(chan_status), .kick_o(seq_kick), .flush_o(dev_flush)
  );

  dmareg_ptr #(.DW(DW), .NSEL(NUM_SEL)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_ok), .idx_i(idx), .wdata_i(reg_wdata),
    .lock_i(chan_status[B_ACT]), .ptr_o(chan_cmdptr), .sel_o(sels)
  );

  dmareg_rdmux #(.DW(DW), .NSEL(NUM_SEL)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_i(reg_rd), .ok_i(ok), .idx_i(idx),
    .status_i(chan_status), .ptr_i(chan_cmdptr), .sel_i(sels),
    .rdata_o(reg_rdata), .rvalid_o(reg_rvalid)
  );

  assign intr_sel   = sels[0];
  assign branch_sel = sels[1];
  assign wait_sel   = sels[2];

  // R11
  partial_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !ok && !seq_kill |=> $stable(chan_status) && $stable(chan_cmdptr) && $stable(sels));
endmodule

// File: tb/dmareg_chan_tb.sv
module dmareg_chan_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0, seq_kill = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [3:0] reg_be = 4'hF;
  logic [31:0] reg_wdata = '0, reg_rdata, chan_cmdptr, intr_sel, branch_sel, wait_sel;
  logic reg_rvalid, seq_kick, dev_flush;
  logic [15:0] chan_status;

  dmareg_chan u_dut (.*);

  int checks = 0, errors = 0;
  logic [15:0] st_m = '0;
  logic last_kick, last_flush;
  logic [31:0] r;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = {idx, 2'b00}; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 4'hF;
    last_kick = seq_kick; last_flush = dev_flush;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = {idx, 2'b00}; reg_be = be;
    @(negedge clk);
    reg_rd = 1'b0; reg_be = 4'hF;
    d = reg_rdata;
    check("R10 rvalid", {31'b0, reg_rvalid}, 32'd1);
  endtask

  task automatic kill();
    @(negedge clk); seq_kill = 1'b1;
    @(negedge clk); seq_kill = 1'b0;
    st_m[10] = 1'b0; st_m[11] = 1'b1;
  endtask

  function automatic logic [15:0] model(input logic [15:0] st, input logic [31:0] w,
                                        output logic k, output logic f);
    logic [15:0] m, v, n;
    m = w[31:16] & 16'hF0FF;
    v = w[15:0]  & 16'hF0FF;
    n = (v & m) | (st & ~m);
    if (n[12]) n[10] = 1'b1;
    if (n[15]) begin n[10] = 1'b1; n[11] = 1'b0; end
    if (n[14]) n[10] = 1'b0;
    if (st[15] && !n[15]) begin n[10] = 1'b0; n[11] = 1'b0; end
    f = n[13];
    n[13] = 1'b0;
    k = n[10];
    return n;
  endfunction

  task automatic ctl(input logic [31:0] w, input string tag);
    logic k, f;
    logic [31:0] s;
    st_m = model(st_m, w, k, f);
    wr(4'd0, w);
    check("R8 kick", {31'b0, last_kick}, {31'b0, k});
    check("R7 flush", {31'b0, last_flush}, {31'b0, f});
    rd(4'd1, s);
    check(tag, s, {16'h0, st_m});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1
    for (int i = 0; i < 16; i++) begin
      rd(4'(i), r);
      check("R1 reset read", r, 32'h0);
    end
    check("R1 pulses", {30'b0, seq_kick, dev_flush}, 32'h0);

    // R2 full sweep over run/pause/flush/wake mask and value
    for (int k = 0; k < 256; k++) begin
      logic [7:0] kb;
      kb = 8'(k);
      if (k % 7 == 3) kill();
      ctl({kb[7:4], 4'h0, kb[0] ? 8'hFF : 8'h00, kb[3:0], 4'h0, kb ^ 8'h5A}, "R2 sweep");
    end
    ctl(32'hFFFF_0000, "R2 clear");

    // R3 reserved bits not loadable
    ctl(32'h0F00_0F00, "R3 idle");
    ctl(32'h8000_8000, "R4 run");
    ctl(32'h0F00_0000, "R3 running");

    // R13 kill while running, then R4 run revives
    kill();
    rd(4'd1, r); check("R13 kill", r, {16'h0, st_m});
    ctl(32'h8000_8000, "R4 revive");
    // R6
    kill();
    ctl(32'h8000_0000, "R6 run drop");
    // R4 wake
    ctl(32'h1000_1000, "R4 wake");
    ctl(32'h1000_0000, "R4 wake clr");
    // R5 pause overrides
    ctl(32'hD000_D000, "R5 pause");
    ctl(32'hF000_0000, "R5 clear");
    // R7 flush alone
    ctl(32'h2000_2000, "R7 flush st");

    // R9 command pointer
    wr(4'd4, 32'h1234_567F);
    rd(4'd4, r); check("R9 align", r, 32'h1234_5670);
    check("R9 port", chan_cmdptr, 32'h1234_5670);
    ctl(32'h8000_8000, "R9 start");
    wr(4'd4, 32'hAAAA_AAA0);
    rd(4'd4, r); check("R9 locked", r, 32'h1234_5670);
    ctl(32'h8000_0000, "R9 stop");
    wr(4'd4, 32'hAAAA_AAA5);
    rd(4'd4, r); check("R9 accepted", r, 32'hAAAA_AAA0);

    // R12 selects
    wr(4'd5, 32'h000F_0003);
    wr(4'd6, 32'h0005_000A);
    wr(4'd7, 32'hDEAD_BEEF);
    rd(4'd5, r); check("R12 intr", r, 32'h000F_0003);
    rd(4'd6, r); check("R12 branch", r, 32'h0005_000A);
    rd(4'd7, r); check("R12 wait", r, 32'hDEAD_BEEF);
    check("R12 ports", intr_sel ^ branch_sel ^ wait_sel, 32'h000F_0003 ^ 32'h0005_000A ^ 32'hDEAD_BEEF);

    // R10 zero registers
    for (int i = 0; i < 16; i++) begin
      if (i == 0 || i == 2 || i == 3 || i >= 8) begin
        if (i != 0) wr(4'(i), 32'hFFFF_FFFF);
        rd(4'(i), r);
        check("R10 zero reg", r, 32'h0);
      end
    end

    // R11 partial accesses
    ctl(32'h00FF_0081, "R11 setup");
    wr(4'd0, 32'h8000_8000, 4'h7);
    check("R11 no kick", {31'b0, last_kick}, 32'h0);
    rd(4'd1, r); check("R11 ctl ignored", r, {16'h0, st_m});
    wr(4'd5, 32'h1111_1111, 4'h3);
    rd(4'd5, r); check("R11 sel ignored", r, 32'h000F_0003);
    rd(4'd1, r, 4'hE); check("R11 partial read", r, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule